// File: doc/BRIEF.md
# ZQ Calibration and ODT Sequencer

This block lives inside a DRAM controller. It schedules impedance calibration of the memory device and drives the on-die-termination pin. When the initialization sequence finishes, the block asks the command scheduler for one long calibration command. It then holds a busy flag for the whole long-calibration window, so that no other command reaches the device during that time. After the window it raises a ready flag. From then on it asks for short calibration commands by itself, spaced by a programmable interval.

Each calibration is a request to the command scheduler. The command goes out only in a cycle where the scheduler grants it and all banks are idle. The interval timer restarts at that moment. The interval is counted in prescaled ticks derived from the clock frequency. A value of zero selects a 100 ms default.

A memory-type input marks DDR2-class parts. For those parts no calibration of either kind is ever requested. The termination pin is independent of calibration. It opens a window around every write burst, leading the first data beat and trailing the last beat by a fixed number of cycles. An enable input can force the pin low.

Top module: `zq_odt_seq`

## Requirements
- R1: After reset, zq_req, zq_busy, cal_ready and odt are low. No request appears while init_done stays low.
- R2: In DDR3 mode (ddr3_mode=1), the cycle after init_done is first seen high, zq_req rises with zq_long=1. The request stays high until it is issued.
- R3: A command is issued, and zq_fire is high, only in a cycle where zq_req, zq_gnt and banks_idle are all high.
- R4: After a long command is issued in cycle t, zq_busy is high for exactly ZQCL_CYC cycles (t+1 to t+ZQCL_CYC). zq_req stays low during that window. cal_ready rises in cycle t+ZQCL_CYC+1 and stays high until reset.
- R5: Short requests carry zq_long=0. Let N be the programmed interval in ticks and P = CLK_HZ/TICK_HZ. With grant and idle banks always present, the first short command goes out N*P+1 cycles after cal_ready rises. Consecutive short commands are max(N*P, ZQCS_CYC)+2 cycles apart.
- R6: zq_interval=0 selects a default interval of TICK_HZ/10 ticks, which is CLK_HZ/10 clocks (100 ms).
- R7: After a short command is issued, zq_busy is high for exactly ZQCS_CYC cycles.
- R8: The interval timer restarts in the cycle a short command is issued. A late grant therefore does not shorten the following spacing.
- R9: With ddr3_mode=0, zq_req and zq_busy never rise, and cal_ready rises the cycle after init_done is seen.
- R10: With odt_en=1, odt is high in cycle c exactly when wr_cmd was high in some cycle from c-(WR_LAT+BURST-1+ODT_LEAD) to c-(WR_LAT-ODT_LEAD). Write data beats start WR_LAT cycles after wr_cmd and last BURST cycles.
- R11: With odt_en=0, odt stays low even while writes are in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ddr3_mode | input | 1 | 1 = device supports ZQ calibration, 0 = DDR2-class |
| init_done | input | 1 | Initialization sequence finished |
| zq_interval | input | IV_W | Short-calibration spacing in ticks, 0 = 100 ms default |
| banks_idle | input | 1 | All banks precharged |
| zq_gnt | input | 1 | Scheduler grant for the pending calibration |
| wr_cmd | input | 1 | Write command issued this cycle |
| odt_en | input | 1 | Termination enable |
| zq_req | output | 1 | Calibration request to the scheduler |
| zq_long | output | 1 | Pending request is the long calibration |
| zq_fire | output | 1 | Calibration issued this cycle |
| zq_busy | output | 1 | Calibration window, blocks the scheduler |
| cal_ready | output | 1 | Long calibration complete |
| odt | output | 1 | Termination pin |

## Verification
zq_req follows init_done one cycle later. zq_fire and odt are combinational, so they are due in the same cycle as the inputs that cause them. zq_busy starts one cycle after the issue, and cal_ready comes one cycle after the busy window ends. The bench changes inputs only at the falling edge and samples two nanoseconds later. It numbers every cycle and compares issue-to-issue spacings and busy lengths against the cycle counts that R4 to R8 give. The termination pin is compared every cycle with a bench-side history of random write commands.

// File: rtl/zq_odt_seq.sv
module zq_odt_seq #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int TICK_HZ  = 1_000,
  parameter int IV_W     = 16,
  parameter int ZQCL_CYC = 512,
  parameter int ZQCS_CYC = 64,
  parameter int WR_LAT   = 5,
  parameter int BURST    = 4,
  parameter int ODT_LEAD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ddr3_mode,
  input  logic            init_done,
  input  logic [IV_W-1:0] zq_interval,
  input  logic            banks_idle,
  input  logic            zq_gnt,
  input  logic            wr_cmd,
  input  logic            odt_en,
  output logic            zq_req,
  output logic            zq_long,
  output logic            zq_fire,
  output logic            zq_busy,
  output logic            cal_ready,
  output logic            odt
);
  localparam int PRESC  = CLK_HZ / TICK_HZ;
  localparam int PW     = $clog2(PRESC + 1);
  localparam int DEF_IV = TICK_HZ / 10;
  localparam int CW     = $clog2(ZQCL_CYC + ZQCS_CYC + 1);
  localparam int ODT_LO = WR_LAT - ODT_LEAD;
  localparam int ODT_HI = WR_LAT + BURST - 1 + ODT_LEAD;

  typedef enum logic [2:0] {S_IDLE, S_LREQ, S_LBUSY, S_RUN, S_SREQ, S_SBUSY} st_t;
  st_t st;
  logic [CW-1:0]   bcnt;
  logic [PW-1:0]   pcnt;
  logic [IV_W-1:0] tcnt;
  logic [IV_W-1:0] iv;
  logic            due;
  logic [ODT_HI:1] wh;
  logic [ODT_HI:0] wv;

  assign iv        = (zq_interval == '0) ? IV_W'(DEF_IV) : zq_interval;
  assign due       = tcnt >= iv;
  assign zq_req    = ddr3_mode && (st == S_LREQ || st == S_SREQ);
  assign zq_long   = zq_req && st == S_LREQ;
  assign zq_fire   = zq_req && zq_gnt && banks_idle;
  assign zq_busy   = st == S_LBUSY || st == S_SBUSY;
  assign cal_ready = st == S_RUN || st == S_SREQ || st == S_SBUSY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      bcnt <= '0;
      pcnt <= '0;
      tcnt <= '0;
    end else begin
      if ((st == S_RUN || st == S_SBUSY) && !due) begin
        if (pcnt == PW'(PRESC - 1)) begin
          pcnt <= '0;
          tcnt <= tcnt + 1'b1;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
      case (st)
        S_IDLE: if (init_done) begin
          st   <= ddr3_mode ? S_LREQ : S_RUN;
          pcnt <= '0;
          tcnt <= '0;
        end
        S_LREQ: if (zq_fire) begin
          st   <= S_LBUSY;
          bcnt <= CW'(ZQCL_CYC - 1);
        end else if (!ddr3_mode) begin
          st <= S_RUN;
        end
        S_LBUSY: if (bcnt == '0) begin
          st   <= S_RUN;
          pcnt <= '0;
          tcnt <= '0;
        end else begin
          bcnt <= bcnt - 1'b1;
        end
        S_RUN: if (due) begin
          if (ddr3_mode) st <= S_SREQ;
          else begin
            pcnt <= '0;
            tcnt <= '0;
          end
        end
        S_SREQ: if (zq_fire) begin
          st   <= S_SBUSY;
          bcnt <= CW'(ZQCS_CYC - 1);
          pcnt <= '0;
          tcnt <= '0;
        end else if (!ddr3_mode) begin
          st <= S_RUN;
        end
        S_SBUSY: if (bcnt == '0) st <= S_RUN;
                 else bcnt <= bcnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wh <= '0;
    else        wh <= {wh[ODT_HI-1:1], wr_cmd};
  end

  assign wv  = {wh, wr_cmd};
  assign odt = odt_en && (|wv[ODT_HI:ODT_LO]);
endmodule

module zq_odt_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ddr3_mode,
  input logic odt_en,
  input logic zq_req,
  input logic zq_long,
  input logic zq_fire,
  input logic zq_busy,
  input logic cal_ready,
  input logic odt
);
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    zq_req && !zq_fire && ddr3_mode |=> zq_req || !ddr3_mode);
  a_r4_busy_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    zq_busy |-> !zq_req);
  a_r4_fire_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    zq_fire |=> zq_busy);
  a_r4_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ready |=> cal_ready);
  a_r5_short_not_long: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ready |-> !zq_long);
  a_r9_ddr2_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !ddr3_mode |-> !zq_req);
  a_r11_odt_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !odt_en |-> !odt);
endmodule

bind zq_odt_seq zq_odt_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ddr3_mode(ddr3_mode), .odt_en(odt_en),
  .zq_req(zq_req), .zq_long(zq_long), .zq_fire(zq_fire),
  .zq_busy(zq_busy), .cal_ready(cal_ready), .odt(odt)
);

// File: tb/zq_odt_seq_tb.sv
module zq_odt_seq_tb;
  localparam int CLK_HZ = 1000, TICK_HZ = 100, P = CLK_HZ / TICK_HZ;
  localparam int ZQCL = 512, ZQCS = 64, WR_LAT = 5, BURST = 4, LEAD = 2;
  localparam int LO = WR_LAT - LEAD, HI = WR_LAT + BURST - 1 + LEAD;

  logic clk = 0, rst_n = 0;
  logic ddr3_mode, init_done, banks_idle, zq_gnt, wr_cmd, odt_en;
  logic [15:0] zq_interval;
  logic zq_req, zq_long, zq_fire, zq_busy, cal_ready, odt;

  logic nx_rst, nx_ddr3, nx_init, nx_idle, nx_gnt, nx_odten;
  logic [15:0] nx_iv;
  bit rnd_wr;
  bit wh [0:15];
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  zq_odt_seq #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .IV_W(16), .ZQCL_CYC(ZQCL),
    .ZQCS_CYC(ZQCS), .WR_LAT(WR_LAT), .BURST(BURST), .ODT_LEAD(LEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .ddr3_mode(ddr3_mode), .init_done(init_done),
    .zq_interval(zq_interval), .banks_idle(banks_idle), .zq_gnt(zq_gnt),
    .wr_cmd(wr_cmd), .odt_en(odt_en), .zq_req(zq_req), .zq_long(zq_long),
    .zq_fire(zq_fire), .zq_busy(zq_busy), .cal_ready(cal_ready), .odt(odt));

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic int exp_odt();
    bit any = 0;
    for (int k = LO; k <= HI; k++) any |= wh[k];
    return int'(odt_en && any);
  endfunction

  task automatic step();
    @(negedge clk);
    rst_n = nx_rst; ddr3_mode = nx_ddr3; init_done = nx_init;
    banks_idle = nx_idle; zq_gnt = nx_gnt; odt_en = nx_odten; zq_interval = nx_iv;
    wr_cmd = rnd_wr ? ($urandom % 5 == 0) : 1'b0;
    for (int k = 15; k > 0; k--) wh[k] = wh[k-1];
    wh[0] = wr_cmd;
    cyc++;
    #2;
    check(odt_en ? "R10 odt window" : "R11 odt disabled", int'(odt), exp_odt());
  endtask

  task automatic wait_fire();
    int g = 0;
    step();
    while (!zq_fire && g < 5000) begin step(); g++; end
  endtask

  initial begin
    #(20 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int r, f0, f1, n;
    bit seen;
    void'($urandom(32'h5EED));
    for (int k = 0; k < 16; k++) wh[k] = 0;
    nx_rst = 0; nx_ddr3 = 1; nx_init = 0; nx_idle = 0; nx_gnt = 0;
    nx_odten = 1; nx_iv = 16'd3; rnd_wr = 0;
    repeat (3) step();
    check("R1 req after reset", int'(zq_req), 0);
    check("R1 busy after reset", int'(zq_busy), 0);
    check("R1 ready after reset", int'(cal_ready), 0);
    check("R1 odt after reset", int'(odt), 0);

    nx_rst = 1; rnd_wr = 1; seen = 0;
    repeat (20) begin step(); seen |= zq_req | cal_ready; end
    check("R1 no request before init_done", int'(seen), 0);

    nx_init = 1; step();
    check("R2 no request in init cycle", int'(zq_req), 0);
    step();
    check("R2 long request raised", int'(zq_req), 1);
    check("R2 long flag", int'(zq_long), 1);
    seen = 0;
    repeat (5) begin step(); seen |= !zq_req | zq_fire; end
    check("R2 request held without grant", int'(seen), 0);
    nx_gnt = 1; seen = 0;
    repeat (3) begin step(); seen |= zq_fire; end
    check("R3 no issue while banks busy", int'(seen), 0);
    nx_idle = 1; step();
    check("R3 issue with grant and idle banks", int'(zq_fire), 1);

    n = 0; seen = 0; step();
    while (zq_busy && n < 2000) begin n++; seen |= cal_ready | zq_req; step(); end
    check("R4 long busy length", n, ZQCL);
    check("R4 ready/request low during busy", int'(seen), 0);
    check("R4 ready after busy", int'(cal_ready), 1);
    r = cyc;

    wait_fire();
    check("R5 first short spacing", cyc - r, 3 * P + 1);
    check("R5 short flag", int'(zq_long), 0);
    f0 = cyc;
    n = 0; step();
    while (zq_busy && n < 2000) begin n++; step(); end
    check("R7 short busy length", n, ZQCS);
    if (!zq_fire) wait_fire();
    check("R5 spacing when interval below busy", cyc - f0, ZQCS + 2);

    nx_iv = 16'd20; f0 = cyc; wait_fire();
    check("R5 spacing 20 ticks", cyc - f0, 20 * P + 2);
    nx_iv = 16'd0; f0 = cyc; wait_fire();
    check("R6 default interval", cyc - f0, CLK_HZ / 10 + 2);

    f0 = cyc; nx_gnt = 0; n = 0;
    step();
    while (!zq_req && n < 5000) begin step(); n++; end
    check("R5 request time default", cyc - f0, CLK_HZ / 10 + 2);
    seen = 0;
    repeat (7) begin step(); seen |= !zq_req | zq_fire; end
    check("R3 request waits for grant", int'(seen), 0);
    nx_gnt = 1; wait_fire(); f1 = cyc;
    wait_fire();
    check("R8 timer restarts at issue", cyc - f1, CLK_HZ / 10 + 2);

    nx_odten = 0; repeat (200) step();
    nx_odten = 1; repeat (100) step();

    rnd_wr = 0; repeat (12) step();
    nx_rst = 0; nx_ddr3 = 0; nx_init = 0; nx_iv = 16'd1;
    repeat (3) step();
    nx_rst = 1; rnd_wr = 1; nx_init = 1; step();
    step();
    check("R9 ready without calibration", int'(cal_ready), 1);
    seen = 0;
    repeat (400) begin step(); seen |= zq_req | zq_busy; end
    check("R9 no calibration in DDR2 mode", int'(seen), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule